// File: doc/BRIEF.md
# Dual-Channel Disk Register Window Decoder

This block sits between a byte-wide host I/O bus and two disk controller channels. It holds five base addresses: one 8-byte command window per channel, one single-byte control location per channel, and one 8-byte DMA window whose two 4-byte halves belong to the two channels. Each host access is matched against these windows, turned into a channel strobe plus a 4-bit register index, and returned as a bus error when nothing matches.

The same offset names different registers depending on direction: the error register reads where the feature register is written, status reads where commands are written, and the alternate status byte reads where device control is written. A separate per-channel pulse marks a real status read, which a channel uses to drop its interrupt, while an alternate status read leaves it alone. Base addresses are loaded through a small configuration port while the bus is quiet.

Top module: `ide_window_decoder`

## Requirements
- R1: After reset the bases are 0x01F0 (command, channel 0), 0x0170 (command, channel 1), 0x03F6 (control, channel 0), 0x0376 (control, channel 1) and 0x0C00 (DMA).
- R2: A read at command-window offset k (offset = address minus base, modulo 2^16, k in 0..7) selects register index k of that window's channel: 0 data, 1 error, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 status.
- R3: A write at command-window offset 1 selects index 8 (feature), at offset 7 index 9 (command); other offsets keep the index k.
- R4: An access exactly at a control base selects index 10 (alternate status) on read and index 11 (device control) on write, for that location's channel.
- R5: DMA offsets 0..3 go to channel 0 and 4..7 to channel 1, with index 12 + (offset mod 4): 12 command, 13 unused, 14 status, 15 unused.
- R6: An access that matches no window raises `bus_err` for that cycle only, drives no channel strobe, and a missed read returns 0x00.
- R7: Windows are matched in the order command 0, command 1, control 0, control 1, DMA; the first match wins on overlap.
- R8: `cfg_we` with `cfg_sel` 0..4 (the order of R7) loads `cfg_base` into that base, used from the next cycle; `cfg_sel` 5..7 changes nothing.
- R9: A read that hits returns the addressed channel's `chN_rdata` on `bus_rdata` in the same cycle.
- R10: `stat_clr[n]` pulses only on a read of index 7 for channel n, never on an alternate status read.
- R11: Without an access all strobes, `acc_reg`, `bus_rdata` and `bus_err` are zero; at most one of the four strobes is high; read and write together act as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Base-address load strobe |
| cfg_sel | input | 3 | Which base to load (0..4) |
| cfg_base | input | 16 | New base address |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 16 | Host address |
| ch0_rdata | input | 8 | Read data from channel 0 |
| ch1_rdata | input | 8 | Read data from channel 1 |
| bus_rdata | output | 8 | Read data to host |
| bus_err | output | 1 | Access matched no window |
| acc_rd | output | 2 | Per-channel read strobe |
| acc_wr | output | 2 | Per-channel write strobe |
| acc_reg | output | 4 | Decoded register index |
| stat_clr | output | 2 | Per-channel status-read pulse |

## Verification
The hardest situation to reach is overlap between windows, since the default bases are disjoint and priority only matters when a reprogrammed base lands inside another window. The stimulus forces one directed overlap and then reloads bases at random from a narrow address range, so windows collide often, while accesses are aimed at addresses near each base so edges of every window and the DMA half split are hit many times.

// File: rtl/ide_window_decoder.sv
module ide_window_decoder #(
  parameter int AW = 16,
  parameter logic [AW-1:0] CMD0_RST = 16'h01F0,
  parameter logic [AW-1:0] CMD1_RST = 16'h0170,
  parameter logic [AW-1:0] CTL0_RST = 16'h03F6,
  parameter logic [AW-1:0] CTL1_RST = 16'h0376,
  parameter logic [AW-1:0] DMA_RST  = 16'h0C00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_base,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    ch0_rdata,
  input  logic [7:0]    ch1_rdata,
  output logic [7:0]    bus_rdata,
  output logic          bus_err,
  output logic [1:0]    acc_rd,
  output logic [1:0]    acc_wr,
  output logic [3:0]    acc_reg,
  output logic [1:0]    stat_clr
);
  localparam int NWIN = 5;
  localparam logic [3:0] IX_STATUS = 4'd7, IX_FEATURE = 4'd8, IX_COMMAND = 4'd9,
                         IX_ALTSTAT = 4'd10, IX_DEVCTL = 4'd11;

  logic [AW-1:0] base_q [NWIN];
  logic [AW-1:0] off    [NWIN];
  logic [NWIN-1:0] hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q[0] <= CMD0_RST;
      base_q[1] <= CMD1_RST;
      base_q[2] <= CTL0_RST;
      base_q[3] <= CTL1_RST;
      base_q[4] <= DMA_RST;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: base_q[0] <= cfg_base;
        3'd1: base_q[1] <= cfg_base;
        3'd2: base_q[2] <= cfg_base;
        3'd3: base_q[3] <= cfg_base;
        3'd4: base_q[4] <= cfg_base;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign off[i] = bus_addr - base_q[i];
    if (i == 2 || i == 3) begin : g_byte
      assign hit[i] = (off[i] == '0);
    end else begin : g_span
      assign hit[i] = (off[i][AW-1:3] == '0);
    end
  end

  wire act   = bus_rd | bus_wr;
  wire is_wr = bus_wr & ~bus_rd;

  logic       found, ch;
  logic [3:0] idx;

  always_comb begin
    found = 1'b1;
    ch    = 1'b0;
    idx   = 4'd0;
    if (hit[0] || hit[1]) begin
      ch  = ~hit[0];
      idx = {1'b0, hit[0] ? off[0][2:0] : off[1][2:0]};
      if (is_wr && idx == 4'd1) idx = IX_FEATURE;
      if (is_wr && idx == IX_STATUS) idx = IX_COMMAND;
    end else if (hit[2] || hit[3]) begin
      ch  = ~hit[2];
      idx = is_wr ? IX_DEVCTL : IX_ALTSTAT;
    end else if (hit[4]) begin
      ch  = off[4][2];
      idx = {2'b11, off[4][1:0]};
    end else begin
      found = 1'b0;
    end
  end

  wire        ok    = act & found;
  wire  [1:0] ch_oh = ch ? 2'b10 : 2'b01;

  assign acc_rd    = (ok && !is_wr) ? ch_oh : 2'b00;
  assign acc_wr    = (ok &&  is_wr) ? ch_oh : 2'b00;
  assign acc_reg   = ok ? idx : 4'd0;
  assign bus_err   = act & ~found;
  assign stat_clr  = (acc_reg == IX_STATUS) ? acc_rd : 2'b00;
  assign bus_rdata = (ok && !is_wr) ? (ch ? ch1_rdata : ch0_rdata) : 8'h00;
endmodule

// File: rtl/ide_window_decoder_chk.sv
module ide_window_decoder_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_sel,
  input logic [AW-1:0] cfg_base,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    ch0_rdata,
  input logic [7:0]    ch1_rdata,
  input logic [7:0]    bus_rdata,
  input logic          bus_err,
  input logic [1:0]    acc_rd,
  input logic [1:0]    acc_wr,
  input logic [3:0]    acc_reg,
  input logic [1:0]    stat_clr
);
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_rd, acc_wr}));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |-> (acc_rd == 2'b00 && acc_wr == 2'b00 && !bus_err && bus_rdata == 8'h00));

  a_r6_err_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (acc_rd == 2'b00 && acc_wr == 2'b00 && bus_rdata == 8'h00));

  a_r6_err_only_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rd || bus_wr));

  a_r3_write_no_read_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr != 2'b00) |-> (acc_reg != 4'd1 && acc_reg != 4'd7 && acc_reg != 4'd10));

  a_r4_read_no_write_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd != 2'b00) |-> (acc_reg != 4'd8 && acc_reg != 4'd9 && acc_reg != 4'd11));

  a_r10_stat_clr_status: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr != 2'b00) |-> (stat_clr == acc_rd && acc_reg == 4'd7));
endmodule

bind ide_window_decoder ide_window_decoder_chk #(.AW(AW)) u_chk (.*);

// File: tb/ide_window_decoder_tb.sv
module ide_window_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [15:0] cfg_base = 16'h0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic [7:0]  ch0_rdata = 8'h00, ch1_rdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        bus_err;
  logic [1:0]  acc_rd, acc_wr, stat_clr;
  logic [3:0]  acc_reg;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] mb [5];

  always #5 clk = ~clk;

  ide_window_decoder u_dut (.*);

  // expected {err, rd[1:0], wr[1:0], reg[3:0], sclr[1:0], rdata[7:0]}
  function automatic logic [18:0] model(input logic rd, input logic wr, input logic [15:0] a,
                                        input logic [7:0] d0, input logic [7:0] d1);
    logic [15:0] o;
    logic f, c, w;
    logic [3:0] ix;
    f = 0; c = 0; ix = 0; w = wr & ~rd;
    if (!(rd | wr)) return '0;
    for (int i = 0; i < 5 && !f; i++) begin
      o = a - mb[i];
      if ((i == 0 || i == 1) && o < 16'd8) begin
        f = 1; c = (i == 1); ix = o[3:0];
        if (w && o == 16'd1) ix = 4'd8;
        if (w && o == 16'd7) ix = 4'd9;
      end else if ((i == 2 || i == 3) && o == 16'd0) begin
        f = 1; c = (i == 3); ix = w ? 4'd11 : 4'd10;
      end else if (i == 4 && o < 16'd8) begin
        f = 1; c = (o >= 16'd4); ix = 4'd12 + o[3:0] % 4;
      end
    end
    if (!f) return {1'b1, 18'd0};
    return {1'b0,
            (!w) ? (c ? 2'b10 : 2'b01) : 2'b00,
            ( w) ? (c ? 2'b10 : 2'b01) : 2'b00,
            ix,
            (!w && ix == 4'd7) ? (c ? 2'b10 : 2'b01) : 2'b00,
            (!w) ? (c ? d1 : d0) : 8'h00};
  endfunction

  task automatic check(input string tag);
    logic [18:0] exp, act;
    exp = model(bus_rd, bus_wr, bus_addr, ch0_rdata, ch1_rdata);
    act = {bus_err, acc_rd, acc_wr, acc_reg, stat_clr, bus_rdata};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s rd=%0b wr=%0b addr=%h actual=%h expected=%h", tag, bus_rd, bus_wr, bus_addr, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic wr, input logic [15:0] a, input string tag);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a;
    ch0_rdata = 8'($urandom); ch1_rdata = 8'($urandom);
    #1 check(tag);
  endtask

  task automatic cfg(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    cfg_we = 1; cfg_sel = s; cfg_base = v;
    @(negedge clk);
    cfg_we = 0;
    if (s < 3'd5) mb[s] = v;
  endtask

  task automatic expect_bits(input string tag, input logic [18:0] exp);
    logic [18:0] act;
    act = {bus_err, acc_rd, acc_wr, acc_reg, stat_clr, bus_rdata};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    mb[0] = 16'h01F0; mb[1] = 16'h0170; mb[2] = 16'h03F6; mb[3] = 16'h0376; mb[4] = 16'h0C00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1 check("R11 idle after reset");
    access(1, 0, 16'h01F7, "R1 R10 status read ch0");
    expect_bits("R10 stat_clr ch0 direct", {1'b0, 2'b01, 2'b00, 4'd7, 2'b01, ch0_rdata});
    access(1, 0, 16'h0170, "R1 R2 R9 data read ch1");
    access(1, 0, 16'h03F6, "R4 R10 altstatus read ch0");
    expect_bits("R10 no stat_clr on altstatus", {1'b0, 2'b01, 2'b00, 4'd10, 2'b00, ch0_rdata});
    access(0, 1, 16'h0376, "R4 devctl write ch1");
    access(0, 1, 16'h0171, "R3 feature write ch1");
    expect_bits("R3 feature index", {1'b0, 2'b00, 2'b10, 4'd8, 2'b00, 8'h00});
    access(0, 1, 16'h0177, "R3 command write ch1");
    access(1, 0, 16'h0171, "R2 error read ch1");
    access(1, 0, 16'h0C05, "R5 dma unused ch1");
    expect_bits("R5 dma index", {1'b0, 2'b10, 2'b00, 4'd13, 2'b00, ch1_rdata});
    access(0, 1, 16'h0C02, "R5 dma status write ch0");
    access(1, 0, 16'h0C08, "R6 just past dma");
    access(1, 0, 16'h0000, "R6 miss read");
    expect_bits("R6 miss read zero", {1'b1, 18'd0});
    access(1, 1, 16'h01F7, "R11 read and write act as read");
    cfg(3'd1, 16'h01F0);
    access(1, 0, 16'h01F3, "R7 overlap cmd0 wins");
    expect_bits("R7 overlap channel", {1'b0, 2'b01, 2'b00, 4'd3, 2'b00, ch0_rdata});
    cfg(3'd5, 16'h4000);
    access(1, 0, 16'h4000, "R8 sel 5 ignored");
    access(1, 0, 16'h01F1, "R8 sel 5 left cmd0");
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'd0; cfg_base = 16'h2000;
    bus_rd = 1; bus_wr = 0; bus_addr = 16'h2000;
    #1 check("R8 load not yet visible");
    @(negedge clk);
    cfg_we = 0; mb[0] = 16'h2000;
    #1 check("R8 load visible next cycle");
    expect_bits("R8 new base hit", {1'b0, 2'b01, 2'b00, 4'd0, 2'b00, ch0_rdata});
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [15:0] a;
      k = int'($urandom % 5);
      if ($urandom % 40 == 0) cfg(3'($urandom % 8), 16'h1000 + 16'($urandom % 24));
      if ($urandom % 2 == 0) a = mb[k] + 16'($urandom % 10) - 16'd1;
      else a = 16'($urandom);
      case ($urandom % 5)
        0: access(0, 0, a, "R11 random idle");
        1, 2: access(1, 0, a, "R2/R4/R5/R6/R7/R9 random read");
        3: access(0, 1, a, "R3/R4/R5/R6/R7 random write");
        default: access(1, 1, a, "R11 random both");
      endcase
    end
    @(negedge clk); bus_rd = 0; bus_wr = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule